// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt request lines and presents them to a processor as two lines: a normal interrupt and a critical interrupt. Software sets up each source through a small register port. A source can be captured on an edge or followed as a level, its sense can be inverted, it can be masked, and it can be routed to either output.

For sources routed to the critical line, the block also computes a vector address: a base value chosen by software, plus a fixed 512-byte step for each priority position of the winning source. Software selects the scan direction that decides which source wins. Software reads and writes registers by offset on a single-cycle write strobe, and read data is returned combinationally from the offset.

A parameter removes the vector logic when it is not needed.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Registers sit at these offsets: 0 status, 1 status-set, 2 enable, 3 critical-select, 4 polarity, 5 trigger, 6 masked status, 7 vector, 8 vector base/config. Offset 1 reads back the status. Every other offset reads zero.
- R2: Input line n drives register bit (31 - n) in every per-source register.
- R3: A trigger bit of 1 selects edge mode. In edge mode, the status bit sets on a 0-to-1 change of (input XOR polarity bit) and holds until software clears it. If a clear and a new edge fall in the same cycle, the bit stays set.
- R4: A trigger bit of 0 selects level mode. In level mode, the status bit equals (input XOR polarity bit) one clock after the input is sampled. A clear write does not drop a bit whose input is still active.
- R5: Writing offset 0 clears the status bits written as 1, within the limits of R3 and R4. Writing offset 1 ORs the written value into status.
- R6: Offset 6 reads status AND enable. Writes to offsets 6 and 7 change no register.
- R7: The normal output is high exactly when (status AND enable AND NOT critical) is non-zero. The critical output is high exactly when (status AND enable AND critical) is non-zero.
- R8: The vector equals the configuration value with bits 1:0 cleared, plus 512 times the scan position of the first pending critical bit. Configuration bit 0 selects the scan: 0 scans from bit 0 upward, and 1 scans from bit 31 downward. The position is counted from the starting bit.
- R9: When no enabled critical source is pending, the vector reads zero.
- R10: A write to the configuration register stores the value with bit 1 forced to 0.
- R11: After reset, status, enable, critical-select, polarity, trigger, configuration and vector all read zero, and both outputs are low.
- R12: With the vector feature removed by parameter, offsets 7 and 8 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Interrupt request lines, line n maps to bit NUM_SRC-1-n |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | NUM_SRC | Write data |
| reg_rdata | output | NUM_SRC | Read data for reg_addr |
| irq_out | output | 1 | Normal interrupt request |
| crit_out | output | 1 | Critical interrupt request |

## Verification
A software clear of the status register can land in the same clock as the capture logic sets the same bit. The bench provokes this in two ways. First, it drives a rising edge on an edge-mode line in the very cycle a clear write to that bit is strobed, and expects the bit to read back as set. Second, it clears a level-mode bit while its input is held active, and expects the bit to stay set until the input drops.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int REG_ADDR_W = 4;

  typedef enum logic [REG_ADDR_W-1:0] {
    OFF_STAT  = 4'd0,
    OFF_SET   = 4'd1,
    OFF_EN    = 4'd2,
    OFF_CRIT  = 4'd3,
    OFF_POL   = 4'd4,
    OFF_TRIG  = 4'd5,
    OFF_MSTAT = 4'd6,
    OFF_VEC   = 4'd7,
    OFF_VCFG  = 4'd8
  } ivc_off_e;
endpackage

// File: rtl/ivc_capture.sv
module ivc_capture #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] trig,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic         set_we,
  input  logic [N-1:0] set_mask,
  output logic [N-1:0] status
);
  logic [N-1:0] act, act_q, rise, clr, set, status_d;

  // next-state
  always_comb begin
    act      = src ^ pol;
    rise     = act & ~act_q;
    clr      = clr_we ? clr_mask : '0;
    set      = set_we ? set_mask : '0;
    // edge bits hold until cleared, a fresh rise beats a clear; level bits track
    status_d = (trig & ((status & ~clr) | rise)) | (~trig & act) | set;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      status <= '0;
    end else begin
      act_q  <= act;
      status <= status_d;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r3_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[i] && status[i] && !(clr_we && clr_mask[i])) |=> status[i]);
    a_r4_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig[i] && !set_we) |=> (status[i] == $past(src[i] ^ pol[i])));
  end
endmodule

// File: rtl/ivc_vecgen.sv
module ivc_vecgen #(
  parameter int N        = 32,
  parameter bit HAS_VEC  = 1'b1,
  parameter int STEP_LG2 = 9
) (
  input  logic [N-1:0] pend,
  input  logic [N-1:0] vcfg,
  output logic [N-1:0] vector
);
  if (HAS_VEC) begin : g_vec
    logic [N-1:0] base;
    logic         found;
    always_comb begin
      base   = vcfg & ~N'(3);
      vector = '0;
      found  = 1'b0;
      for (int i = 0; i < N; i++) begin
        int idx;
        idx = vcfg[0] ? (N - 1 - i) : i;
        if (!found && pend[idx]) begin
          found  = 1'b1;
          vector = base + (N'(i) << STEP_LG2);
        end
      end
    end
  end else begin : g_novec
    assign vector = '0;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_SRC      = 32,
  parameter bit HAS_VECTOR   = 1'b1,
  parameter int VEC_STEP_LG2 = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    irq_in,
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [NUM_SRC-1:0]    reg_wdata,
  output logic [NUM_SRC-1:0]    reg_rdata,
  output logic                  irq_out,
  output logic                  crit_out
);
  localparam logic [NUM_SRC-1:0] VCFG_KEEP = ~NUM_SRC'(2);

  logic [NUM_SRC-1:0] src_bits, status, vector, crit_pend, norm_pend;
  logic [NUM_SRC-1:0] en_q, en_d, crit_q, crit_d, pol_q, pol_d, trig_q, trig_d;
  logic [NUM_SRC-1:0] vcfg_q;
  logic wr_stat, wr_set, wr_en, wr_crit, wr_pol, wr_trig, wr_vcfg;

  // line n -> bit NUM_SRC-1-n
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_map
    assign src_bits[NUM_SRC-1-n] = irq_in[n];
  end

  // write decode
  always_comb begin
    wr_stat = reg_wr && (reg_addr == OFF_STAT);
    wr_set  = reg_wr && (reg_addr == OFF_SET);
    wr_en   = reg_wr && (reg_addr == OFF_EN);
    wr_crit = reg_wr && (reg_addr == OFF_CRIT);
    wr_pol  = reg_wr && (reg_addr == OFF_POL);
    wr_trig = reg_wr && (reg_addr == OFF_TRIG);
    wr_vcfg = reg_wr && (reg_addr == OFF_VCFG);
  end

  // next-state for configuration
  always_comb begin
    en_d   = wr_en   ? reg_wdata : en_q;
    crit_d = wr_crit ? reg_wdata : crit_q;
    pol_d  = wr_pol  ? reg_wdata : pol_q;
    trig_d = wr_trig ? reg_wdata : trig_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      crit_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
    end else begin
      en_q   <= en_d;
      crit_q <= crit_d;
      pol_q  <= pol_d;
      trig_q <= trig_d;
    end
  end

  if (HAS_VECTOR) begin : g_vcfg
    logic [NUM_SRC-1:0] vcfg_d;
    always_comb vcfg_d = wr_vcfg ? (reg_wdata & VCFG_KEEP) : vcfg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vcfg_q <= '0;
      else        vcfg_q <= vcfg_d;
    end
  end else begin : g_no_vcfg
    assign vcfg_q = '0;
  end

  ivc_capture #(.N(NUM_SRC)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (src_bits),
    .pol      (pol_q),
    .trig     (trig_q),
    .clr_we   (wr_stat),
    .clr_mask (reg_wdata),
    .set_we   (wr_set),
    .set_mask (reg_wdata),
    .status   (status)
  );

  always_comb begin
    crit_pend = status & en_q & crit_q;
    norm_pend = status & en_q & ~crit_q;
  end

  ivc_vecgen #(.N(NUM_SRC), .HAS_VEC(HAS_VECTOR), .STEP_LG2(VEC_STEP_LG2)) u_vecgen (
    .pend   (crit_pend),
    .vcfg   (vcfg_q),
    .vector (vector)
  );

  assign irq_out  = |norm_pend;
  assign crit_out = |crit_pend;

  // read mux
  always_comb begin
    case (reg_addr)
      OFF_STAT, OFF_SET: reg_rdata = status;
      OFF_EN:            reg_rdata = en_q;
      OFF_CRIT:          reg_rdata = crit_q;
      OFF_POL:           reg_rdata = pol_q;
      OFF_TRIG:          reg_rdata = trig_q;
      OFF_MSTAT:         reg_rdata = status & en_q;
      OFF_VEC:           reg_rdata = vector;
      OFF_VCFG:          reg_rdata = vcfg_q;
      default:           reg_rdata = '0;
    endcase
  end

  a_r7_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (!irq_out && !crit_out));
  a_r9_vec_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !crit_out |-> (vector == '0));
  a_r10_vcfg_bit1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vcfg |=> (vcfg_q[1] == 1'b0));
  a_r6_mstat_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_MSTAT) |=> ($stable(en_q) && $stable(crit_q) && $stable(vcfg_q)));
  a_r8_vec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    vector[1:0] == 2'b00);
endmodule

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, rdata_nv;
  logic        irq_out, crit_out, irq_nv, crit_nv;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .crit_out(crit_out));

  irq_vector_ctrl #(.HAS_VECTOR(1'b0)) dut_nv (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_nv),
    .irq_out(irq_nv), .crit_out(crit_nv));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), d);
      check("R11 reset value", d, 32'h0);
    end
    check("R11 outputs low", {30'h0, irq_out, crit_out}, 32'h0);
  endtask

  task automatic t_offsets();
    logic [31:0] d;
    wr(4'd2, 32'hA5A5_0F0F); rd(4'd2, d); check("R1 enable", d, 32'hA5A5_0F0F);
    wr(4'd3, 32'h1234_5678); rd(4'd3, d); check("R1 critical", d, 32'h1234_5678);
    wr(4'd4, 32'h0000_FFFF); rd(4'd4, d); check("R1 polarity", d, 32'h0000_FFFF);
    wr(4'd5, 32'hFFFF_0000); rd(4'd5, d); check("R1 trigger", d, 32'hFFFF_0000);
    rd(4'd9, d);  check("R1 unmapped 9", d, 32'h0);
    rd(4'd15, d); check("R1 unmapped 15", d, 32'h0);
    wr(4'd2, 0); wr(4'd3, 0); wr(4'd4, 0); wr(4'd5, 0); wr(4'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(4'd5, 32'hFFFF_FFFF); wr(4'd2, 32'hFFFF_FFFF); wr(4'd0, 32'hFFFF_FFFF);
    @(negedge clk) irq_in[0] = 1'b1;
    @(negedge clk) irq_in[0] = 1'b0;
    rd(4'd0, d); check("R2 R3 edge set on bit 31", d, 32'h8000_0000);
    check("R7 normal out", {31'h0, irq_out}, 32'h1);
    wr(4'd0, 32'h8000_0000); rd(4'd0, d); check("R5 clear", d, 32'h0);
    // coincident clear and new edge on line 5 (bit 26)
    wr(4'd1, 32'h0400_0000);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h0400_0000; irq_in[5] = 1'b1;
    @(negedge clk) reg_wr = 1'b0;
    rd(4'd0, d); check("R3 edge beats clear", d, 32'h0400_0000);
    irq_in[5] = 1'b0;
    wr(4'd0, 32'h0400_0000); rd(4'd0, d); check("R3 cleared after", d, 32'h0);
    // inverted polarity on line 3 (bit 28)
    wr(4'd4, 32'h1000_0000); wr(4'd0, 32'hFFFF_FFFF);
    @(negedge clk) irq_in[3] = 1'b1;
    @(negedge clk);
    rd(4'd0, d); check("R3 inverted, no set on input rise", d, 32'h0);
    @(negedge clk) irq_in[3] = 1'b0;
    @(negedge clk);
    rd(4'd0, d); check("R3 inverted, set on input fall", d, 32'h1000_0000);
    wr(4'd4, 0); wr(4'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(4'd5, 32'h0);
    @(negedge clk) irq_in[7] = 1'b1;
    @(negedge clk);
    rd(4'd0, d); check("R4 level follows high", d, 32'h0100_0000);
    wr(4'd0, 32'h0100_0000); rd(4'd0, d); check("R4 clear while active", d, 32'h0100_0000);
    @(negedge clk) irq_in[7] = 1'b0;
    @(negedge clk);
    rd(4'd0, d); check("R4 level follows low", d, 32'h0);
  endtask

  task automatic t_set_mask();
    logic [31:0] d;
    wr(4'd5, 32'hFFFF_FFFF); wr(4'd1, 32'h0000_00F0); wr(4'd1, 32'h0000_0003);
    rd(4'd1, d); check("R5 set ORs", d, 32'h0000_00F3);
    wr(4'd2, 32'h0000_0031);
    rd(4'd6, d); check("R6 masked status", d, 32'h0000_0031);
    wr(4'd6, 32'hFFFF_FFFF); wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd0, d); check("R6 status untouched", d, 32'h0000_00F3);
    rd(4'd2, d); check("R6 enable untouched", d, 32'h0000_0031);
    rd(4'd8, d); check("R6 config untouched", d, 32'h0);
    wr(4'd3, 32'h0000_0031);
    check("R7 all critical", {30'h0, irq_out, crit_out}, 32'h1);
    wr(4'd3, 32'h0000_0001);
    check("R7 mixed", {30'h0, irq_out, crit_out}, 32'h3);
    wr(4'd2, 0);
    check("R7 masked off", {30'h0, irq_out, crit_out}, 32'h0);
    wr(4'd0, 32'hFFFF_FFFF); wr(4'd3, 0);
  endtask

  task automatic t_vector();
    logic [31:0] d;
    wr(4'd8, 32'h1000_0003); rd(4'd8, d); check("R10 bit1 dropped", d, 32'h1000_0001);
    rd(4'd7, d); check("R9 idle vector", d, 32'h0);
    wr(4'd2, 32'hFFFF_FFFF); wr(4'd3, 32'h0010_0010); wr(4'd1, 32'h0010_0010);
    rd(4'd7, d); check("R8 descending", d, 32'h1000_1600);
    wr(4'd8, 32'h1000_0000);
    rd(4'd7, d); check("R8 ascending", d, 32'h1000_0800);
    rd(4'd7, d); d = rdata_nv; check("R12 no vector", d, 32'h0);
    reg_addr = 4'd8; #1 check("R12 no config", rdata_nv, 32'h0);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd7, d); check("R9 vector zero when none pending", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_offsets();
    t_edge();
    t_level();
    t_set_mask();
    t_vector();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule